// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch program counter and proposes the next fetch address in the same cycle. It keeps two tables, both indexed by low bits of the word-aligned PC. The first is a direction table of two-bit saturating counters. The second is a tagged target cache that holds the destination of branches seen taken before. Fetch is sent to a stored target only when the target cache hits and the counter for that PC leans taken. In every other case the next address is the sequential PC plus four.

Later in the pipeline, a branch is resolved. Its PC, its actual outcome and its actual destination come back on the resolve port, together with what fetch had predicted for it. The block trains both tables from this information. One cycle later it raises a flush with the corrected fetch address whenever the earlier guess was wrong. The hysteresis in the counters means a loop-closing branch costs one misprediction per loop exit, not two.

Top module: `fetch_predictor`

## Requirements
- R1: After reset every direction counter holds weakly not-taken (01) and every target entry is invalid, so each fetch PC predicts not taken with next PC = PC+4, and flush is low.
- R2: The prediction is taken, with next PC equal to the stored target, only when the target entry at index PC[5:2] is valid, its tag equals PC[31:6], and the direction counter at index PC[7:2] is 10 or 11. Otherwise the prediction is not taken and the next PC is PC+4. Both outputs are combinational from the current fetch PC.
- R3: On each resolve, the counter at index PC[7:2] of the resolved PC steps up on taken and down on not taken, saturating at 11 and 00. The predicted direction therefore changes only after two mispredictions in a row from a strong state.
- R4: Each resolved taken branch writes its target entry: valid set, tag from PC[31:6], target equal to the actual target. A resolved not-taken branch leaves the target entry unchanged.
- R5: Flush is high in the cycle after a resolve exactly when the predicted direction differs from the actual one, or when the branch was taken and the predicted next PC differs from the actual target.
- R6: While flush is high, the redirect PC equals the resolved target if the branch was taken, and the resolved PC+4 otherwise.
- R7: A cycle with no resolve changes no table state and gives flush low in the following cycle.
- R8: A loop-closing branch that is trained by repeated traversals of a nested loop mispredicts exactly once per inner-loop exit after the first outer pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc_i | input | 32 | PC being fetched this cycle |
| pred_taken_o | output | 1 | Fetch is predicted to take a branch |
| pred_next_pc_o | output | 32 | Predicted next fetch PC |
| res_valid_i | input | 1 | A branch resolution is presented |
| res_pc_i | input | 32 | PC of the resolved branch |
| res_taken_i | input | 1 | Actual branch direction |
| res_target_i | input | 32 | Actual taken destination |
| res_pred_taken_i | input | 1 | Direction that fetch predicted for this branch |
| res_pred_target_i | input | 32 | Next PC that fetch used for this branch |
| flush_o | output | 1 | Misprediction detected; flush younger work |
| redirect_pc_o | output | 32 | Corrected fetch PC, meaningful when flush is high |

## Verification
The prediction outputs are due in the same cycle as the fetch PC. They reflect only resolves that were clocked in before that cycle. The bench drives the inputs just after a falling edge and samples the predictions one time step later, before the model learns of this cycle's resolve. Flush and redirect come from a register, so they are due one rising edge after the resolve. The bench compares them at the next falling edge against the expectation it stored for the previous step.

// File: rtl/fp_pkg.sv
package fp_pkg;

   typedef enum logic [1:0] {
      CTR_SNT = 2'b00,
      CTR_WNT = 2'b01,
      CTR_WT  = 2'b10,
      CTR_ST  = 2'b11
   } ctr_e;

   function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
      ctr_e nxt;
      nxt = cur;
      if (taken && cur != CTR_ST)
         nxt = ctr_e'(cur + 2'b01);
      else if (!taken && cur != CTR_SNT)
         nxt = ctr_e'(cur - 2'b01);
      return nxt;
   endfunction

endpackage

// File: rtl/fp_dir_table.sv
module fp_dir_table
   import fp_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int IDX_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_taken,
   input  logic            upd_en,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);
   localparam int DEPTH = 1 << IDX_W;

   ctr_e             tbl [DEPTH];
   logic [IDX_W-1:0] ridx;
   logic [IDX_W-1:0] uidx;

   assign ridx     = rd_pc[2 +: IDX_W];
   assign uidx     = upd_pc[2 +: IDX_W];
   assign rd_taken = tbl[ridx][1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WNT;
      end else if (upd_en) begin
         tbl[uidx] <= ctr_step(tbl[uidx], upd_taken);
      end
   end

   // R3: counters saturate at both ends
   a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_taken && tbl[uidx] == CTR_ST) |=> tbl[$past(uidx)] == CTR_ST);
   a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_taken && tbl[uidx] == CTR_SNT) |=> tbl[$past(uidx)] == CTR_SNT);
   // R3: a strong taken counter survives one not-taken outcome
   a_r3_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_taken && tbl[uidx] == CTR_ST) |=> tbl[$past(uidx)] == CTR_WT);

endmodule

// File: rtl/fp_target_cache.sv
module fp_target_cache #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int TAG_W = PC_W - 2 - IDX_W;

   logic [DEPTH-1:0] vld;
   logic [TAG_W-1:0] tag_mem [DEPTH];
   logic [PC_W-1:0]  tgt_mem [DEPTH];

   logic [IDX_W-1:0] ridx;
   logic [IDX_W-1:0] widx;

   assign ridx      = rd_pc[2 +: IDX_W];
   assign widx      = wr_pc[2 +: IDX_W];
   assign rd_hit    = vld[ridx] && (tag_mem[ridx] == rd_pc[PC_W-1 -: TAG_W]);
   assign rd_target = tgt_mem[ridx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (wr_en) begin
         vld[widx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[widx] <= wr_pc[PC_W-1 -: TAG_W];
         tgt_mem[widx] <= wr_target;
      end
   end

   // R4: a written entry is valid and holds the written target
   a_r4_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld[$past(widx)]);
   a_r4_target_stored: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> tgt_mem[$past(widx)] == $past(wr_target));
   // R1: nothing hits before any write after reset
   a_r1_cold_miss: assert property (@(posedge clk)
      $past(!rst_n) && !$past(wr_en) |-> vld == '0);

endmodule

// File: rtl/fp_mispredict.sv
module fp_mispredict #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_pred_taken,
   input  logic [PC_W-1:0] res_pred_target,
   output logic            flush,
   output logic [PC_W-1:0] redirect_pc
);
   logic dir_wrong;
   logic tgt_wrong;
   logic [PC_W-1:0] fix_pc;

   assign dir_wrong = res_pred_taken != res_taken;
   assign tgt_wrong = res_taken && (res_pred_target != res_target);
   assign fix_pc    = res_taken ? res_target : res_pc + PC_W'(4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush       <= 1'b0;
         redirect_pc <= '0;
      end else begin
         flush       <= res_valid && (dir_wrong || tgt_wrong);
         redirect_pc <= fix_pc;
      end
   end

   // R7: no flush without a resolve one cycle earlier
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> !flush);
   // R6: redirect destination for taken and not-taken flushes
   a_r6_taken_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken) |=> (!flush || redirect_pc == $past(res_target)));
   a_r6_fall_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_taken) |=> (!flush || redirect_pc == $past(res_pc) + PC_W'(4)));
   // R5: a correct prediction never flushes
   a_r5_correct_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken == res_pred_taken && (!res_taken || res_target == res_pred_target))
      |=> !flush);

endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor
   import fp_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int DIR_IDX_W = 6,
   parameter int TGT_IDX_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc_i,
   output logic            pred_taken_o,
   output logic [PC_W-1:0] pred_next_pc_o,
   input  logic            res_valid_i,
   input  logic [PC_W-1:0] res_pc_i,
   input  logic            res_taken_i,
   input  logic [PC_W-1:0] res_target_i,
   input  logic            res_pred_taken_i,
   input  logic [PC_W-1:0] res_pred_target_i,
   output logic            flush_o,
   output logic [PC_W-1:0] redirect_pc_o
);
   localparam int MAX_IDX = PC_W - 3;

   generate
      if (DIR_IDX_W < 1 || DIR_IDX_W > 12)
         $error("fetch_predictor: DIR_IDX_W out of range");
      if (TGT_IDX_W < 1 || TGT_IDX_W > MAX_IDX || TGT_IDX_W > 10)
         $error("fetch_predictor: TGT_IDX_W out of range");
      if (PC_W < 8)
         $error("fetch_predictor: PC_W too small");
   endgenerate

   logic            dir_taken;
   logic            tgt_hit;
   logic [PC_W-1:0] tgt_addr;

   fp_dir_table #(.PC_W(PC_W), .IDX_W(DIR_IDX_W)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc_i),
      .rd_taken  (dir_taken),
      .upd_en    (res_valid_i),
      .upd_pc    (res_pc_i),
      .upd_taken (res_taken_i)
   );

   fp_target_cache #(.PC_W(PC_W), .IDX_W(TGT_IDX_W)) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc_i),
      .rd_hit    (tgt_hit),
      .rd_target (tgt_addr),
      .wr_en     (res_valid_i && res_taken_i),
      .wr_pc     (res_pc_i),
      .wr_target (res_target_i)
   );

   fp_mispredict #(.PC_W(PC_W)) u_mis (
      .clk             (clk),
      .rst_n           (rst_n),
      .res_valid       (res_valid_i),
      .res_pc          (res_pc_i),
      .res_taken       (res_taken_i),
      .res_target      (res_target_i),
      .res_pred_taken  (res_pred_taken_i),
      .res_pred_target (res_pred_target_i),
      .flush           (flush_o),
      .redirect_pc     (redirect_pc_o)
   );

   assign pred_taken_o   = tgt_hit && dir_taken;
   assign pred_next_pc_o = pred_taken_o ? tgt_addr : fetch_pc_i + PC_W'(4);

   // R2: a taken prediction needs a target hit
   a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken_o |-> tgt_hit);
   // R2: a miss in the target cache falls through
   a_r2_miss_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_hit |-> pred_next_pc_o == fetch_pc_i + PC_W'(4));

endmodule

// File: tb/fetch_predictor_tb_top.sv
module fetch_predictor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] fetch_pc;
   logic        pred_taken;
   logic [31:0] pred_next;
   logic        res_valid;
   logic [31:0] res_pc;
   logic        res_taken;
   logic [31:0] res_target;
   logic        res_pred_taken;
   logic [31:0] res_pred_target;
   logic        flush;
   logic [31:0] redirect_pc;

   int n_checks = 0;
   int n_errors = 0;

   int          m_ctr  [64];
   bit          m_vld  [16];
   logic [25:0] m_tag  [16];
   logic [31:0] m_tgt  [16];
   bit          exp_flush;
   logic [31:0] exp_redir;
   bit          last_pt;
   logic [31:0] last_pn;

   always #10 clk = ~clk;

   fetch_predictor dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .fetch_pc_i        (fetch_pc),
      .pred_taken_o      (pred_taken),
      .pred_next_pc_o    (pred_next),
      .res_valid_i       (res_valid),
      .res_pc_i          (res_pc),
      .res_taken_i       (res_taken),
      .res_target_i      (res_target),
      .res_pred_taken_i  (res_pred_taken),
      .res_pred_target_i (res_pred_target),
      .flush_o           (flush),
      .redirect_pc_o     (redirect_pc)
   );

   function automatic bit model_taken(input logic [31:0] pc);
      int d = int'(pc[7:2]);
      int t = int'(pc[5:2]);
      return m_vld[t] && m_tag[t] == pc[31:6] && m_ctr[d] >= 2;
   endfunction

   function automatic logic [31:0] model_next(input logic [31:0] pc);
      return model_taken(pc) ? m_tgt[int'(pc[5:2])] : pc + 32'd4;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 64; i++) m_ctr[i] = 1;
      for (int i = 0; i < 16; i++) m_vld[i] = 0;
      exp_flush = 0;
      exp_redir = '0;
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                       input bit rt, input logic [31:0] rtgt, input bit rpt,
                       input logic [31:0] rptgt);
      bit ept;
      logic [31:0] epn;
      @(negedge clk);
      // R5 / R6 / R7: registered outcome of the previous step
      check(flush == exp_flush, "R5/R7 flush", {31'd0, flush}, {31'd0, exp_flush});
      if (exp_flush)
         check(redirect_pc == exp_redir, "R6 redirect", redirect_pc, exp_redir);
      fetch_pc        = fpc;
      res_valid       = rv;
      res_pc          = rpc;
      res_taken       = rt;
      res_target      = rtgt;
      res_pred_taken  = rpt;
      res_pred_target = rptgt;
      #1;
      ept = model_taken(fpc);
      epn = model_next(fpc);
      check(pred_taken == ept, "R2 pred_taken", {31'd0, pred_taken}, {31'd0, ept});
      check(pred_next == epn, "R2 pred_next", pred_next, epn);
      last_pt = pred_taken;
      last_pn = pred_next;
      exp_flush = rv && ((rpt != rt) || (rt && rptgt != rtgt));
      exp_redir = rt ? rtgt : rpc + 32'd4;
      if (rv) begin
         int d = int'(rpc[7:2]);
         int t = int'(rpc[5:2]);
         if (rt && m_ctr[d] < 3) m_ctr[d]++;
         if (!rt && m_ctr[d] > 0) m_ctr[d]--;
         if (rt) begin
            m_vld[t] = 1;
            m_tag[t] = rpc[31:6];
            m_tgt[t] = rtgt;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      res_valid = 0;
      fetch_pc = '0;
      res_pc = '0;
      res_taken = 0;
      res_target = '0;
      res_pred_taken = 0;
      res_pred_target = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   function automatic logic [31:0] rnd_pc();
      return {18'd0, 2'($urandom_range(0, 3)), 10'($urandom_range(0, 255) << 2), 2'b00};
   endfunction

   initial begin
      #(20ns * 200000);
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] in_pc  = 32'h0000_0100;
      logic [31:0] in_tgt = 32'h0000_00F0;
      logic [31:0] out_pc = 32'h0000_0120;
      logic [31:0] out_tgt = 32'h0000_00C0;
      void'($urandom(32'd1234));
      do_reset();

      // R1: cold predictions fall through, no flush
      for (int i = 0; i < 4; i++)
         step(rnd_pc(), 0, '0, 0, '0, 0, '0);
      @(negedge clk);
      check(flush == 0, "R1 flush after reset", {31'd0, flush}, 32'd0);

      // R8 / R3: nested loop, inner branch taken 3 times then exits
      for (int round = 0; round < 4; round++) begin
         int mis = 0;
         for (int it = 0; it < 4; it++) begin
            bit tk = (it < 3);
            bit pt;
            logic [31:0] pn;
            step(in_pc, 0, '0, 0, '0, 0, '0);
            pt = last_pt;
            pn = last_pn;
            if (round > 0 && it == 0)
               check(pt == 1, "R3 hysteresis keeps taken", {31'd0, pt}, 32'd1);
            if ((pt != tk) || (tk && pn != in_tgt)) mis++;
            step(in_pc, 1, in_pc, tk, in_tgt, pt, pn);
         end
         step(out_pc, 0, '0, 0, '0, 0, '0);
         step(out_pc, 1, out_pc, 1, out_tgt, last_pt, last_pn);
         if (round > 0)
            check(mis == 1, "R8 one mispredict per exit", mis, 1);
      end

      // R4: not-taken resolve keeps the target entry, alias with other tag misses
      step(32'h0000_0040, 1, 32'h0000_0040, 1, 32'h0000_0800, 0, 32'h44);
      step(32'h0000_0040, 1, 32'h0000_0040, 1, 32'h0000_0800, 1, 32'h0000_0800);
      step(32'h0000_0040, 1, 32'h0000_0040, 0, 32'h0000_0999, 1, 32'h0000_0800);
      step(32'h0000_0040, 0, '0, 0, '0, 0, '0);
      check(pred_next == 32'h0000_0800, "R4 entry kept after not-taken", pred_next, 32'h0000_0800);
      step(32'h0000_1040, 0, '0, 0, '0, 0, '0);
      check(pred_next == 32'h0000_1044, "R2 tag mismatch falls through", pred_next, 32'h0000_1044);

      // R7: idle cycles keep predictions
      for (int i = 0; i < 3; i++) step(32'h0000_0040, 0, '0, 0, '0, 0, '0);

      // Constrained random traffic, R5 / R6 on mixed prediction quality
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rpc  = rnd_pc();
         logic [31:0] rtgt = rnd_pc();
         bit          rt   = 1'($urandom_range(0, 1));
         bit          rv   = ($urandom_range(0, 3) != 0);
         bit          rpt  = 1'($urandom_range(0, 1));
         logic [31:0] rptg = ($urandom_range(0, 1) != 0) ? rtgt : rnd_pc();
         step(rnd_pc(), rv, rpc, rt, rtgt, rpt, rptg);
      end
      step(32'h0, 0, '0, 0, '0, 0, '0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule